// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter with Status Register

This block is the transmit half of an asynchronous serial port. It has one data holding register and one shift register behind it. Software writes bytes into the holding register. The block moves each byte into the shift register when the shifter is free and the transmitter is enabled. A one-cycle bit-clock enable input sets the pace at which the shifter puts the frame on the line.

A status register tells software about the state of the transmitter. Some of its bits are flags that the hardware owns: the holding register is free, the shifter ran dry while enabled, and the transmitter went quiet after being switched off. The other bits are controls that software writes: transmitter enable, break, the level the line holds when idle, and a turnaround flag that is only stored. A CPU write changes the control bits only. A read strobe clears the underrun flag once it has been read. The word length, parity and stop-bit count come from static configuration inputs, which may change only while the shifter is empty.

Top module: `usart_tx_core`

## Requirements
- R1: After reset the status register reads 0x00, no byte is pending, the shifter is empty, and the line is released (txd_oe = 0, because idle code 00 means high impedance).
- R2: A status write changes only the bits selected by mask 0x2F (bit 5 turnaround, bit 3 break, bits 2:1 idle code, bit 0 enable). Bit 7 buffer-empty, bit 6 underrun and bit 4 end-of-transmission keep their values.
- R3: A data write stores the byte, marks it pending and clears bit 7. If bit 0 is set and the shifter is empty, the byte is loaded on the same edge: bit 7 reads 1 again in the next cycle and the start bit is on the line.
- R4: A frame is a low start bit, then N = 5 + cfg_wlen data bits with the least significant bit first, then a parity bit when cfg_par_en = 1, then one high stop bit (two when cfg_two_stop = 1). The parity bit is the XOR of the data bits when cfg_par_odd = 0 and its inverse when cfg_par_odd = 1. The start bit holds from the load until the first bit_en pulse. Each later bit holds for one bit_en interval.
- R5: When a frame ends with bit 0 set and a byte pending, that byte is loaded on the same edge, bit 7 is set and the next frame follows with no gap.
- R6: When a frame ends with bit 0 set and nothing pending, bit 6 (underrun) is set.
- R7: When a frame ends with bit 0 clear, bit 4 (end-of-transmission) is set.
- R8: A status write with bit 0 = 0 clears bit 6. It also sets bit 4 if the shifter is empty at that moment.
- R9: A status write with bit 0 = 1 clears bit 4. A pending byte is then loaded at once if the shifter is empty, and bit 7 is set.
- R10: stat_rdata always shows the register. A cycle with stat_re high clears bit 6 afterwards.
- R11: Bit 3 (break) drives the line low with txd_oe = 1. Otherwise a busy shifter drives its frame bit. An empty shifter with bit 0 set drives high. An empty shifter with bit 0 clear follows idle code bits 2:1: 00 releases the line, 01 drives low, 10 and 11 drive high.
- R12: A byte written while bit 0 is clear is held and not sent. The line stays at its idle level until the transmitter is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle pulse per serial bit time |
| cfg_wlen | input | 2 | Word length code, N = 5 + code |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | Odd parity when 1, even when 0 |
| cfg_two_stop | input | 1 | Two stop bits when 1 |
| data_we | input | 1 | Write strobe for the holding register |
| data_wdata | input | DATA_W | Byte to send |
| stat_we | input | 1 | Write strobe for the status register |
| stat_wdata | input | 8 | Status write data (mask 0x2F applied) |
| stat_re | input | 1 | Read strobe, clears underrun afterwards |
| stat_rdata | output | 8 | Current status register |
| txd | output | 1 | Serial line data |
| txd_oe | output | 1 | Line drive enable (0 = high impedance) |

## Verification
A wrong pending flag or a wrong shifter-busy state shows up at the ports. A lost or duplicated byte is visible in the serial stream one frame time later. A wrong flag update is visible in stat_rdata on the cycle after the event, for example underrun raised while a byte was still waiting, or end-of-transmission raised while a frame is still shifting. A mis-assembled frame shows up as a wrong bit at the first bit position that differs, within at most twelve bit_en intervals of the load. Idle and break mis-muxing shows on txd/txd_oe in the cycle after the status write.

// File: rtl/usart_tx_pkg.sv
package usart_tx_pkg;
   localparam int ST_W  = 8;
   localparam int B_EN  = 0;
   localparam int B_BRK = 3;
   localparam int B_EOT = 4;
   localparam int B_ATN = 5;
   localparam int B_UE  = 6;
   localparam int B_BE  = 7;
   localparam logic [ST_W-1:0] WR_MASK = 8'h2F;

   typedef enum logic [1:0] {
      IDLE_HIZ   = 2'b00,
      IDLE_LOW   = 2'b01,
      IDLE_HIGH  = 2'b10,
      IDLE_HIGH2 = 2'b11
   } idle_e;
endpackage

// File: rtl/usart_tx_shift.sv
module usart_tx_shift #(
   parameter int DATA_W = 8,
   parameter int MIN_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic [1:0]        wlen,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              two_stop,
   output logic              busy,
   output logic              done,
   output logic              sbit
);
   localparam int FRAME_W = DATA_W + 4;
   localparam int CNT_W   = $clog2(FRAME_W + 1);

   logic [FRAME_W-1:0] sreg_q, frame;
   logic [CNT_W-1:0]   cnt_q, total;
   logic               busy_q;

   always_comb begin
      int                 nbits;
      logic [DATA_W-1:0]  lmask;
      logic [FRAME_W-1:0] body;
      logic               par;
      nbits = MIN_W + int'(wlen);
      if (nbits > DATA_W) nbits = DATA_W;
      lmask = ~({DATA_W{1'b1}} << nbits);
      par   = (^(load_data & lmask)) ^ par_odd;
      body  = {{(FRAME_W-DATA_W){1'b1}}, load_data | ~lmask};
      if (par_en) body[nbits] = par;
      frame = {body[FRAME_W-2:0], 1'b0};
      total = CNT_W'(2 + nbits + int'(par_en) + int'(two_stop));
   end

   assign done = busy_q && bit_en && (cnt_q == CNT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         sreg_q <= '1;
      end else if (load) begin
         busy_q <= 1'b1;
         cnt_q  <= total;
         sreg_q <= frame;
      end else if (busy_q && bit_en) begin
         if (cnt_q == CNT_W'(1)) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            sreg_q <= '1;
         end else begin
            cnt_q  <= cnt_q - CNT_W'(1);
            sreg_q <= {1'b1, sreg_q[FRAME_W-1:1]};
         end
      end
   end

   assign busy = busy_q;
   assign sbit = sreg_q[0];
endmodule

// File: rtl/usart_tx_ctrl.sv
module usart_tx_ctrl
   import usart_tx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              data_we,
   input  logic [DATA_W-1:0] data_wdata,
   input  logic              stat_we,
   input  logic [ST_W-1:0]   stat_wdata,
   input  logic              stat_re,
   input  logic              sh_busy,
   input  logic              sh_done,
   output logic [ST_W-1:0]   status,
   output logic              load,
   output logic [DATA_W-1:0] load_data
);
   logic [ST_W-1:0]   st_q, st_d;
   logic              pend_q, pend_d;
   logic [DATA_W-1:0] hold_q, hold_d;

   always_comb begin
      st_d   = st_q;
      pend_d = pend_q;
      hold_d = hold_q;
      load   = 1'b0;
      if (stat_we) begin
         st_d = (st_q & ~WR_MASK) | (stat_wdata & WR_MASK);
         if (!stat_wdata[B_EN]) begin
            st_d[B_UE] = 1'b0;
            if (!sh_busy) st_d[B_EOT] = 1'b1;
         end else begin
            st_d[B_EOT] = 1'b0;
         end
      end
      if (stat_re) st_d[B_UE] = 1'b0;
      if (data_we) begin
         hold_d     = data_wdata;
         pend_d     = 1'b1;
         st_d[B_BE] = 1'b0;
      end
      if (sh_done) begin
         if (!st_d[B_EN])  st_d[B_EOT] = 1'b1;
         else if (!pend_d) st_d[B_UE]  = 1'b1;
      end
      if (st_d[B_EN] && pend_d && (!sh_busy || sh_done)) begin
         load       = 1'b1;
         pend_d     = 1'b0;
         st_d[B_BE] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= '0;
         pend_q <= 1'b0;
         hold_q <= '0;
      end else begin
         st_q   <= st_d;
         pend_q <= pend_d;
         hold_q <= hold_d;
      end
   end

   assign status    = st_q;
   assign load_data = hold_d;
endmodule

// File: rtl/usart_tx_line.sv
module usart_tx_line
   import usart_tx_pkg::*;
#(
   parameter bit HIZ_EN = 1'b1
) (
   input  logic       brk,
   input  logic       en,
   input  logic [1:0] idle_code,
   input  logic       busy,
   input  logic       sbit,
   output logic       txd,
   output logic       txd_oe
);
   logic idle_lvl, idle_oe;

   generate
      if (HIZ_EN) begin : g_hiz
         assign idle_oe  = (idle_e'(idle_code) != IDLE_HIZ);
         assign idle_lvl = (idle_e'(idle_code) != IDLE_LOW);
      end else begin : g_nohiz
         assign idle_oe  = 1'b1;
         assign idle_lvl = (idle_e'(idle_code) != IDLE_LOW);
      end
   endgenerate

   always_comb begin
      if (brk) begin
         txd = 1'b0; txd_oe = 1'b1;
      end else if (busy) begin
         txd = sbit; txd_oe = 1'b1;
      end else if (en) begin
         txd = 1'b1; txd_oe = 1'b1;
      end else begin
         txd = idle_lvl; txd_oe = idle_oe;
      end
   end
endmodule

// File: rtl/usart_tx_core.sv
module usart_tx_core
   import usart_tx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int MIN_W  = 5,
   parameter bit HIZ_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic [1:0]        cfg_wlen,
   input  logic              cfg_par_en,
   input  logic              cfg_par_odd,
   input  logic              cfg_two_stop,
   input  logic              data_we,
   input  logic [DATA_W-1:0] data_wdata,
   input  logic              stat_we,
   input  logic [7:0]        stat_wdata,
   input  logic              stat_re,
   output logic [7:0]        stat_rdata,
   output logic              txd,
   output logic              txd_oe
);
   generate
      if (DATA_W < MIN_W || DATA_W > 8) begin : g_bad_width
         $error("usart_tx_core: DATA_W must lie between MIN_W and 8");
      end
      if (MIN_W < 1 || MIN_W + 3 < DATA_W) begin : g_bad_min
         $error("usart_tx_core: MIN_W must let the 2-bit length code reach DATA_W");
      end
   endgenerate

   logic              sh_busy, sh_done, sh_bit, ld;
   logic [DATA_W-1:0] ld_data;

   usart_tx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .data_we(data_we), .data_wdata(data_wdata),
      .stat_we(stat_we), .stat_wdata(stat_wdata), .stat_re(stat_re),
      .sh_busy(sh_busy), .sh_done(sh_done),
      .status(stat_rdata), .load(ld), .load_data(ld_data)
   );

   usart_tx_shift #(.DATA_W(DATA_W), .MIN_W(MIN_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
      .load(ld), .load_data(ld_data),
      .wlen(cfg_wlen), .par_en(cfg_par_en), .par_odd(cfg_par_odd),
      .two_stop(cfg_two_stop),
      .busy(sh_busy), .done(sh_done), .sbit(sh_bit)
   );

   usart_tx_line #(.HIZ_EN(HIZ_EN)) u_line (
      .brk(stat_rdata[B_BRK]), .en(stat_rdata[B_EN]),
      .idle_code(stat_rdata[2:1]), .busy(sh_busy), .sbit(sh_bit),
      .txd(txd), .txd_oe(txd_oe)
   );
endmodule

// File: rtl/usart_tx_chk.sv
module usart_tx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       stat_we,
   input logic [7:0] stat_wdata,
   input logic       stat_re,
   input logic       data_we,
   input logic [7:0] stat_rdata,
   input logic       txd,
   input logic       txd_oe,
   input logic       sh_busy,
   input logic       sh_done
);
   // R2: control bits take the written value
   assert_ctrl_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
      stat_we |=> ((stat_rdata & 8'h2F) == ($past(stat_wdata) & 8'h2F)));

   // R2: a disabling write leaves buffer-empty alone
   assert_keep_be_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_we && !stat_wdata[0] && !data_we && !sh_done) |=> (stat_rdata[7] == $past(stat_rdata[7])));

   // R3: a byte written while disabled clears buffer-empty
   assert_be_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (data_we && !stat_we && !stat_rdata[0]) |=> !stat_rdata[7]);

   // R7: frame end while disabled raises end-of-transmission
   assert_eot_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sh_done && !stat_rdata[0] && !stat_we) |=> stat_rdata[4]);

   // R8: disabling with the shifter empty
   assert_dis_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_we && !stat_wdata[0] && !sh_busy) |=> (stat_rdata[4] && !stat_rdata[6]));

   // R9: enabling clears end-of-transmission
   assert_en_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_we && stat_wdata[0]) |=> !stat_rdata[4]);

   // R10: read strobe clears underrun
   assert_rd_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_re && !sh_done) |=> !stat_rdata[6]);

   // R11: break holds the line low and driven
   assert_break_R11: assert property (@(posedge clk) disable iff (!rst_n)
      stat_rdata[3] |-> (!txd && txd_oe));
endmodule

bind usart_tx_core usart_tx_chk u_chk (
   .clk(clk), .rst_n(rst_n), .stat_we(stat_we), .stat_wdata(stat_wdata),
   .stat_re(stat_re), .data_we(data_we), .stat_rdata(stat_rdata),
   .txd(txd), .txd_oe(txd_oe), .sh_busy(sh_busy), .sh_done(sh_done)
);

// File: tb/usart_tx_core_tb.sv
`timescale 1ns/1ps
module usart_tx_core_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_en = 1'b0;
   logic [1:0] cfg_wlen = 2'd3;
   logic       cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0;
   logic       data_we = 1'b0, stat_we = 1'b0, stat_re = 1'b0;
   logic [7:0] data_wdata = '0, stat_wdata = '0;
   logic [7:0] stat_rdata;
   logic       txd, txd_oe;

   int n_chk = 0, n_fail = 0;
   bit done_flag = 1'b0;
   bit mon_on = 1'b0;
   logic [11:0] exp_q[$];
   logic [11:0] got_q[$];

   always #2.5 clk = ~clk;

   usart_tx_core u_dut (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
      .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
      .cfg_two_stop(cfg_two_stop),
      .data_we(data_we), .data_wdata(data_wdata),
      .stat_we(stat_we), .stat_wdata(stat_wdata), .stat_re(stat_re),
      .stat_rdata(stat_rdata), .txd(txd), .txd_oe(txd_oe)
   );

   function automatic int frame_len(logic [1:0] wl, logic pe, logic ts);
      return 2 + 5 + int'(wl) + int'(pe) + int'(ts);
   endfunction

   function automatic logic [11:0] exp_frame(logic [7:0] d, logic [1:0] wl,
                                             logic pe, logic po, logic ts);
      logic [11:0] f;
      int n;
      int k;
      logic p;
      f = '0;
      n = 5 + int'(wl);
      p = po;
      for (int i = 0; i < n; i++) begin
         f[1+i] = d[i];
         p = p ^ d[i];
      end
      k = 1 + n;
      if (pe) begin f[k] = p; k++; end
      f[k] = 1'b1; k++;
      if (ts) f[k] = 1'b1;
      return f;
   endfunction

   task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // bit clock: one pulse every four cycles
   initial begin
      int ph = 0;
      forever begin
         @(negedge clk);
         bit_en = (ph == 3);
         ph = (ph + 1) % 4;
      end
   end

   // line monitor: samples each bit just before the shift edge
   initial begin
      bit in_fr = 1'b0;
      int idx = 0;
      logic [11:0] cur = '0;
      forever begin
         @(negedge clk);
         #1;
         if (mon_on && rst_n && bit_en && txd_oe) begin
            if (!in_fr) begin
               if (txd == 1'b0) begin
                  in_fr = 1'b1; cur = '0; idx = 1;
               end
            end else begin
               cur[idx] = txd;
               idx++;
            end
            if (in_fr && idx == frame_len(cfg_wlen, cfg_par_en, cfg_two_stop)) begin
               got_q.push_back(cur);
               in_fr = 1'b0;
            end
         end
      end
   end

   task automatic wr_stat(logic [7:0] v);
      @(negedge clk); stat_we = 1'b1; stat_wdata = v;
      @(negedge clk); stat_we = 1'b0;
   endtask

   task automatic wr_data(logic [7:0] v, bit expect_tx);
      if (expect_tx) exp_q.push_back(exp_frame(v, cfg_wlen, cfg_par_en, cfg_par_odd, cfg_two_stop));
      @(negedge clk); data_we = 1'b1; data_wdata = v;
      @(negedge clk); data_we = 1'b0;
   endtask

   task automatic rd_stat(output logic [7:0] v);
      @(negedge clk); v = stat_rdata; stat_re = 1'b1;
      @(negedge clk); stat_re = 1'b0;
   endtask

   task automatic wait_frames(string req);
      int t = 0;
      while (got_q.size() < exp_q.size() && t < 3000) begin
         @(negedge clk); t++;
      end
      repeat (3) @(negedge clk);
      check(got_q.size() == exp_q.size(), req, got_q.size(), exp_q.size());
      while (exp_q.size() > 0 && got_q.size() > 0) begin
         logic [11:0] g, e;
         g = got_q.pop_front();
         e = exp_q.pop_front();
         check(g == e, req, g, e);
      end
      exp_q.delete();
      got_q.delete();
   endtask

   initial begin
      logic [7:0] rv;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(stat_rdata == 8'h00, "R1 status after reset", stat_rdata, 8'h00);
      check(txd_oe == 1'b0, "R1 line released after reset", txd_oe, 0);

      wr_stat(8'hFF);
      check(stat_rdata == 8'h2F, "R2 write mask", stat_rdata, 8'h2F);
      check(txd == 1'b0 && txd_oe, "R11 break drives low", {txd_oe, txd}, 2'b10);

      wr_stat(8'h05);
      check(stat_rdata == 8'h05, "R9 enable write", stat_rdata, 8'h05);
      check(txd == 1'b1 && txd_oe, "R11 enabled empty line high", {txd_oe, txd}, 2'b11);

      mon_on = 1'b1;
      wr_data(8'hA5, 1'b1);
      check(stat_rdata == 8'h85, "R3 immediate load sets buffer-empty", stat_rdata, 8'h85);
      check(txd == 1'b0, "R3 start bit on line", txd, 0);
      wr_data(8'h3C, 1'b1);
      check(stat_rdata[7] == 1'b0, "R3 pending clears buffer-empty", stat_rdata, 8'h05);
      wait_frames("R5 back-to-back frames R4");
      check(stat_rdata == 8'hC5, "R6 underrun after last frame", stat_rdata, 8'hC5);

      rd_stat(rv);
      check(rv == 8'hC5, "R10 read returns value", rv, 8'hC5);
      rd_stat(rv);
      check(rv == 8'h85, "R10 read cleared underrun", rv, 8'h85);

      wr_data(8'h0F, 1'b1);
      wait_frames("R4 single frame");
      wr_stat(8'h05);
      check(stat_rdata == 8'hC5, "R2 flags kept on status write", stat_rdata, 8'hC5);
      wr_stat(8'h04);
      check(stat_rdata == 8'h94, "R8 disable clears underrun sets eot", stat_rdata, 8'h94);

      mon_on = 1'b0;
      wr_stat(8'h02);
      check(txd == 1'b0 && txd_oe, "R11 idle low", {txd_oe, txd}, 2'b10);
      wr_stat(8'h00);
      check(txd_oe == 1'b0, "R11 idle high impedance", txd_oe, 0);
      check(stat_rdata == 8'h90, "R2 flags kept", stat_rdata, 8'h90);
      wr_stat(8'h04);
      mon_on = 1'b1;

      wr_data(8'h5A, 1'b0);
      check(stat_rdata == 8'h14, "R12 held byte clears buffer-empty", stat_rdata, 8'h14);
      repeat (60) @(negedge clk);
      check(got_q.size() == 0, "R12 nothing sent while disabled", got_q.size(), 0);
      check(txd == 1'b1 && txd_oe, "R12 line idle while pending", {txd_oe, txd}, 2'b11);
      exp_q.push_back(exp_frame(8'h5A, cfg_wlen, cfg_par_en, cfg_par_odd, cfg_two_stop));
      wr_stat(8'h05);
      check(stat_rdata == 8'h85, "R9 enable loads pending", stat_rdata, 8'h85);
      check(txd == 1'b0, "R9 start bit after enable", txd, 0);
      wait_frames("R9 pending frame R4");

      wr_stat(8'h04);
      wr_stat(8'h05);
      check(stat_rdata == 8'h85, "R9 enable clears eot", stat_rdata, 8'h85);
      wr_data(8'h99, 1'b1);
      repeat (8) @(negedge clk);
      wr_stat(8'h04);
      check(stat_rdata == 8'h84, "R8 no eot while shifting", stat_rdata, 8'h84);
      wait_frames("R7 frame finishes after disable");
      check(stat_rdata == 8'h94, "R7 eot at frame end", stat_rdata, 8'h94);

      begin
         int seed = $urandom(32'h1234);
         seed = 0;
         for (int it = 0; it < 40; it++) begin
            int nb;
            @(negedge clk);
            cfg_wlen = 2'($urandom_range(0, 3));
            cfg_par_en = 1'($urandom_range(0, 1));
            cfg_par_odd = 1'($urandom_range(0, 1));
            cfg_two_stop = 1'($urandom_range(0, 1));
            wr_stat(8'h05);
            nb = $urandom_range(1, 3);
            for (int b = 0; b < nb; b++) begin
               int t = 0;
               while (!stat_rdata[7] && t < 500) begin @(negedge clk); t++; end
               repeat ($urandom_range(0, 20)) @(negedge clk);
               wr_data(8'($urandom_range(0, 255)), 1'b1);
            end
            wait_frames("R4 random frames R5");
            wr_stat(8'h04);
            check(stat_rdata == 8'h94, "R8 random disable", stat_rdata, 8'h94);
         end
      end

      done_flag = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done_flag) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule